// File: doc/BRIEF.md
# Bunch Veto Command Transmitter

This block drives the second fast command line of a detector clock-and-control fan-out. At every bunch while a train is running it sends one short frame that tells the front-end electronics whether that bunch is to be vetoed. A frame is a 3-bit header, the 12-bit bunch number and 4 reserved bits. The header is one pattern for "veto" and another for "keep". Each bit is Manchester coded so that the line can be AC coupled at the receiver.

The block runs on the bit clock, which has 22 periods per bunch period. A one-cycle phase strobe marks the start of each bunch period. On an accepted strobe the block captures the decision and the bunch number. It then holds the launch back by a programmable number of bit clocks, from 0 to 10, so that the frame lands at the right phase at the front end. Bunch numbers beyond the last legal bunch are clamped and reported. Each bit leaves as a two-phase symbol pair, first half then second half, for a double-rate output stage. With no frame in flight the line carries Manchester zeros.

Top module: `bunch_veto_tx`

## Requirements
- R1: While reset is asserted and after it is released, `line_sym` is 2'b10, `frame_active` is 0 and `id_err` is 0 until a strobe is accepted.
- R2: With no frame in flight, `line_sym` is 2'b10 (a Manchester zero). A strobe that arrives while `train_active` is 0 is ignored: no frame follows and `id_err` stays 0.
- R3: The first three frame bits are the header. It is 1,1,0 when `veto_req` was 1 at the strobe and 1,0,1 when it was 0.
- R4: Frame bits 3 to 14 carry the 12-bit bunch number, most significant bit first. Bits 15 to 18 are zeros. The frame is exactly 19 bits long and the line then returns to idle.
- R5: Each bit is sent as `line_sym` = {first half, second half}: a 1 is 2'b01 and a 0 is 2'b10. The values 2'b00 and 2'b11 never appear.
- R6: Let the strobe be sampled at clock edge k and let the offset be n = min(`phase_ofs`, 10). Frame bit i is on `line_sym` from edge k+n+1+i. An offset value above 10 acts as 10.
- R7: A bunch number of 3000 or more on an accepted strobe is sent as 2999. In that case `id_err` is 1 for the single cycle that follows edge k; otherwise it is 0.
- R8: `frame_active` is 1 for exactly the 19 cycles in which frame bits are on the line.
- R9: The decision and the bunch number are taken at the strobe. Later changes of `veto_req` and `bunch_num` do not alter the frame.
- R10: Lowering `train_active` after a strobe has been accepted does not cut short the frame already queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 22 periods per bunch period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bunch_strobe | input | 1 | One-cycle marker of the bunch-period phase |
| train_active | input | 1 | High while a bunch train is running |
| veto_req | input | 1 | 1 = veto this bunch, 0 = keep it |
| bunch_num | input | 12 | Bunch number that goes with the decision |
| phase_ofs | input | 4 | Launch delay in bit clocks, 0..10 (larger values act as 10) |
| line_sym | output | 2 | Manchester symbol pair {first half, second half} |
| id_err | output | 1 | One-cycle flag: the bunch number was out of range and was clamped |
| frame_active | output | 1 | High while frame bits are on the line |

## Verification
The clamp flag is due in the cycle right after the strobe edge. Frame bit i is due n+1+i edges after the strobe edge, and the line is idle in every other cycle. The bench raises the strobe at a falling edge and holds it over one rising edge. It then samples at each later falling edge and compares `line_sym`, `frame_active` and `id_err` against a window it computes from the clamped offset, so a frame that is off by one cycle fails on the spot. Right after the strobe edge the bench changes the captured inputs, and sometimes drops `train_active`, to check that only the values taken at the strobe edge reach the line.

// File: rtl/bvtx_pkg.sv
package bvtx_pkg;
  localparam int HDR_W   = 3;
  localparam int ID_W    = 12;
  localparam int RSV_W   = 4;
  localparam int FRAME_W = HDR_W + ID_W + RSV_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [HDR_W-1:0] HDR_VETO = 3'b110;
  localparam logic [HDR_W-1:0] HDR_KEEP = 3'b101;

  // Symbol pair {first half, second half}
  localparam logic [1:0] SYM_ZERO = 2'b10;
  localparam logic [1:0] SYM_ONE  = 2'b01;

  typedef struct packed {
    logic            valid;
    logic            veto;
    logic [ID_W-1:0] id;
  } slot_t;

  typedef enum logic {S_IDLE = 1'b0, S_SEND = 1'b1} ser_state_e;

  function automatic logic [1:0] manch_sym(input logic b);
    return b ? SYM_ONE : SYM_ZERO;
  endfunction
endpackage

// File: rtl/bvtx_rst_sync.sv
module bvtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bvtx_capture.sv
module bvtx_capture
  import bvtx_pkg::*;
#(
  parameter int ID_LIMIT = 3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic            train_i,
  input  logic            veto_i,
  input  logic [ID_W-1:0] id_i,
  output slot_t           slot_o,
  output logic            err_o
);
  localparam logic [ID_W-1:0] ID_TOP = ID_W'(ID_LIMIT - 1);

  logic            take;
  logic            over;
  logic [ID_W-1:0] id_clamped;
  logic            valid_q, valid_n;
  logic            err_q, err_n;
  logic            veto_q;
  logic [ID_W-1:0] id_q;

  always_comb begin
    take       = strobe_i & train_i;
    over       = (id_i > ID_TOP);
    id_clamped = over ? ID_TOP : id_i;
    valid_n    = take;
    err_n      = take & over;
  end

  // flags every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      err_q   <= err_n;
    end
  end

  // payload only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      veto_q <= 1'b0;
      id_q   <= '0;
    end else if (take) begin
      veto_q <= veto_i;
      id_q   <= id_clamped;
    end
  end

  assign slot_o = '{valid: valid_q, veto: veto_q, id: id_q};
  assign err_o  = err_q;
endmodule

// File: rtl/bvtx_phase_delay.sv
module bvtx_phase_delay
  import bvtx_pkg::*;
#(
  parameter int MAX_OFS = 10,
  parameter int OFS_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            slot_i,
  input  logic [OFS_W-1:0] ofs_i,
  output slot_t            tap_o
);
  localparam logic [OFS_W-1:0] OFS_TOP = OFS_W'(MAX_OFS);

  slot_t            stage [0:MAX_OFS];
  logic [OFS_W-1:0] ofs_eff;

  assign stage[0] = slot_i;

  for (genvar j = 1; j <= MAX_OFS; j++) begin : g_stage
    logic            v_q;
    logic            veto_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= stage[j-1].valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        veto_q <= 1'b0;
        id_q   <= '0;
      end else if (stage[j-1].valid) begin
        veto_q <= stage[j-1].veto;
        id_q   <= stage[j-1].id;
      end
    end

    assign stage[j] = '{valid: v_q, veto: veto_q, id: id_q};
  end

  always_comb begin
    ofs_eff = (ofs_i > OFS_TOP) ? OFS_TOP : ofs_i;
    tap_o   = stage[0];
    for (int j = 0; j <= MAX_OFS; j++) begin
      if (ofs_eff == OFS_W'(j)) tap_o = stage[j];
    end
  end
endmodule

// File: rtl/bvtx_serializer.sv
module bvtx_serializer
  import bvtx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            veto_i,
  input  logic [ID_W-1:0] id_i,
  output logic [1:0]      sym_o,
  output logic            active_o
);
  ser_state_e         st_q, st_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   left_q, left_n;
  logic               en;

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    left_n = left_q;
    en     = load_i | (st_q == S_SEND);
    if (load_i) begin
      sh_n   = {(veto_i ? HDR_VETO : HDR_KEEP), id_i, {RSV_W{1'b0}}};
      left_n = CNT_W'(FRAME_W);
      st_n   = S_SEND;
    end else if (st_q == S_SEND) begin
      sh_n   = {sh_q[FRAME_W-2:0], 1'b0};
      left_n = left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) st_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      left_q <= left_n;
    end
  end

  assign active_o = (st_q == S_SEND);
  assign sym_o    = active_o ? manch_sym(sh_q[FRAME_W-1]) : SYM_ZERO;
endmodule

// File: rtl/bunch_veto_tx.sv
module bunch_veto_tx
  import bvtx_pkg::*;
#(
  parameter int MAX_OFS    = 10,
  parameter int OFS_W      = 4,
  parameter int ID_LIMIT   = 3000,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bunch_strobe,
  input  logic             train_active,
  input  logic             veto_req,
  input  logic [ID_W-1:0]  bunch_num,
  input  logic [OFS_W-1:0] phase_ofs,
  output logic [1:0]       line_sym,
  output logic             id_err,
  output logic             frame_active
);
  logic  rst_int_n;
  slot_t slot0;
  slot_t tap;

  bvtx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bvtx_capture #(.ID_LIMIT(ID_LIMIT)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (bunch_strobe),
    .train_i  (train_active),
    .veto_i   (veto_req),
    .id_i     (bunch_num),
    .slot_o   (slot0),
    .err_o    (id_err)
  );

  bvtx_phase_delay #(.MAX_OFS(MAX_OFS), .OFS_W(OFS_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .slot_i (slot0),
    .ofs_i  (phase_ofs),
    .tap_o  (tap)
  );

  bvtx_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (tap.valid),
    .veto_i   (tap.veto),
    .id_i     (tap.id),
    .sym_o    (line_sym),
    .active_o (frame_active)
  );
endmodule

// File: rtl/bunch_veto_tx_chk.sv
module bunch_veto_tx_chk #(
  parameter int ID_LIMIT = 3000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bunch_strobe,
  input logic        train_active,
  input logic [11:0] bunch_num,
  input logic [1:0]  line_sym,
  input logic        id_err,
  input logic        frame_active
);
  logic [4:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (frame_active) run_q <= run_q + 5'd1;
    else                   run_q <= '0;
  end

  // R2: idle line carries Manchester zeros
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> line_sym == 2'b10);

  // R5: only the two legal symbol pairs appear
  p_sym_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym == 2'b10 || line_sym == 2'b01);

  // R3: both headers lead with a 1
  p_hdr_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> line_sym == 2'b01);

  // R7: the clamp flag only follows an accepted out-of-range strobe
  p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> $past(bunch_strobe && train_active && (bunch_num >= 12'(ID_LIMIT))));

  // R8: a finished frame lasted exactly 19 cycles
  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_active) |-> run_q == 5'd19);
endmodule

bind bunch_veto_tx bunch_veto_tx_chk #(.ID_LIMIT(ID_LIMIT)) u_chk (.*);

// File: tb/bunch_veto_tx_tb.sv
module bunch_veto_tx_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bunch_strobe;
  logic        train_active;
  logic        veto_req;
  logic [11:0] bunch_num;
  logic [3:0]  phase_ofs;
  logic [1:0]  line_sym;
  logic        id_err;
  logic        frame_active;

  int checks;
  int errors;
  bit done;

  bunch_veto_tx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bunch_strobe (bunch_strobe),
    .train_active (train_active),
    .veto_req     (veto_req),
    .bunch_num    (bunch_num),
    .phase_ofs    (phase_ofs),
    .line_sym     (line_sym),
    .id_err       (id_err),
    .frame_active (frame_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] exp_frame(input logic v, input logic [11:0] id);
    logic [11:0] cid;
    cid = (id >= 12'd3000) ? 12'd2999 : id;
    return {(v ? 3'b110 : 3'b101), cid, 4'b0000};
  endfunction

  // Strobe at a falling edge, sample at every later falling edge
  task automatic run_frame(input logic v, input logic [11:0] id, input logic [3:0] ofs,
                           input logic accept, input logic drop_train);
    int          n;
    logic [18:0] f;
    logic        bad;
    n   = (ofs > 4'd10) ? 10 : int'(ofs);
    f   = exp_frame(v, id);
    bad = accept && (id >= 12'd3000);
    phase_ofs    = ofs;
    train_active = accept;
    veto_req     = v;
    bunch_num    = id;
    bunch_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bunch_strobe = 1'b0;
    veto_req     = ~v;            // R9: changes after capture
    bunch_num    = 12'($urandom);
    if (drop_train) train_active = 1'b0;  // R10
    check("R7 flag after strobe", {31'd0, id_err}, {31'd0, bad});
    for (int c = 1; c <= n + 21; c++) begin
      int   idx;
      bit   inf;
      logic [1:0] es;
      @(posedge clk);
      @(negedge clk);
      idx = c - n - 1;
      inf = accept && idx >= 0 && idx < 19;
      es  = inf ? (f[18-idx] ? 2'b01 : 2'b10) : 2'b10;
      if (!inf && c <= n)  check("R6 R2 idle before launch", {30'd0, line_sym}, {30'd0, es});
      else if (!inf)       check("R2 R4 idle after frame", {30'd0, line_sym}, {30'd0, es});
      else if (idx < 3)    check("R3 R5 R6 header bit", {30'd0, line_sym}, {30'd0, es});
      else if (idx < 15)   check("R4 R9 R10 bunch bit", {30'd0, line_sym}, {30'd0, es});
      else                 check("R4 reserved bit", {30'd0, line_sym}, {30'd0, es});
      check("R8 frame_active", {31'd0, frame_active}, {31'd0, inf});
      check("R7 flag single cycle", {31'd0, id_err}, 32'd0);
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    void'($urandom(32'h5eed_0b17));
    rst_n        = 1'b0;
    bunch_strobe = 1'b0;
    train_active = 1'b0;
    veto_req     = 1'b0;
    bunch_num    = '0;
    phase_ofs    = '0;
    repeat (3) @(negedge clk);
    check("R1 reset line", {30'd0, line_sym}, 32'h2);
    check("R1 reset active", {31'd0, frame_active}, 32'd0);
    check("R1 reset flag", {31'd0, id_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release line", {30'd0, line_sym}, 32'h2);
    check("R1 after release active", {31'd0, frame_active}, 32'd0);

    // Directed corner cases
    run_frame(1'b1, 12'd0,    4'd0,  1'b1, 1'b0);
    run_frame(1'b0, 12'd2999, 4'd10, 1'b1, 1'b0);
    run_frame(1'b1, 12'd3000, 4'd3,  1'b1, 1'b0);
    run_frame(1'b0, 12'd4095, 4'd11, 1'b1, 1'b0);
    run_frame(1'b1, 12'd1365, 4'd15, 1'b1, 1'b1);
    run_frame(1'b1, 12'd3500, 4'd5,  1'b0, 1'b0);  // R2: ignored strobe
    run_frame(1'b0, 12'd2730, 4'd1,  1'b1, 1'b1);

    // Random mix
    for (int k = 0; k < 60; k++) begin
      run_frame(1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
                4'($urandom_range(0, 15)), ($urandom_range(0, 7) != 0),
                ($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule